// File: doc/BRIEF.md
# Two-Lane Byte-Wise Sample Deserializer

This block turns three double-data-rate serial lanes into parallel converter samples. One lane carries the upper byte of each 16-bit word, a second lane carries the lower byte, and a third lane carries the frame clock. All three arrive as bit pairs that the pad logic has already captured on both clock edges. Shifting and word assembly take place in ordinary registers. No dedicated serializer cells are used.

The frame-clock lane is treated as data. The block searches all eight bit offsets of that lane for the frame marker and declares lock once the marker stays on one offset for several frames. It then applies that single offset to both data lanes at the same time. Both bytes of a word therefore always come from the same frame, and the upper byte of one sample is never joined to the lower byte of the next.

The 14-bit sample is emitted as a 16-bit sign-extended value with a one-cycle valid strobe. A control input selects whether the incoming samples are two's complement or offset binary.

Top module: `lvds_word_deser`

## Requirements
- R1: While reset is asserted and after it is released, `sample_o`, `valid_o` and `locked_o` are all zero until lock is first gained.
- R2: Each clock cycle delivers two bits per lane, and the rising-edge bit is the earlier of the two. Each lane sends 8 bits per frame, MSB first, so one frame lasts 4 cycles. The upper lane carries word bits 15:8 and the lower lane carries word bits 7:0.
- R3: A frame begins where an 8-bit window of the frame lane reads 11110000, oldest bit first. The window may start at any of the 8 bit positions in a frame, both odd and even.
- R4: `locked_o` rises after the marker has been seen at the same offset in 4 consecutive frames. It changes on the clock edge after the edge that registers that frame's final bit pair.
- R5: A single frame with no marker keeps lock, and that frame's word is still delivered. Two consecutive frames with no marker drop lock, and no word is delivered for the second one. After the drop, 4 fresh matching frames are needed to lock again.
- R6: Both bytes of an output word come from the same frame, including the frames where the lower byte wraps from 0xFF to 0x00.
- R7: Word bits 15:14 are padding and have no effect on the output. Output bits 15:14 repeat output bit 13.
- R8: When `fmt_offset` is 1, sample bit 13 is inverted, which converts offset binary to two's complement. When it is 0, the sample passes through unchanged. The sample is sign-extended after this step.
- R9: While locked, `valid_o` pulses for exactly one cycle per frame, on the edge after the one that registers the frame's last bit pair. `sample_o` holds its value between pulses.
- R10: While `locked_o` is 0, `valid_o` is 0 and `sample_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one DDR bit pair per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_rise | input | 1 | Upper-byte lane, rising-edge bit (earlier) |
| hi_fall | input | 1 | Upper-byte lane, falling-edge bit (later) |
| lo_rise | input | 1 | Lower-byte lane, rising-edge bit |
| lo_fall | input | 1 | Lower-byte lane, falling-edge bit |
| fr_rise | input | 1 | Frame-clock lane, rising-edge bit |
| fr_fall | input | 1 | Frame-clock lane, falling-edge bit |
| fmt_offset | input | 1 | 1: incoming samples are offset binary |
| sample_o | output | 16 | Sign-extended sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| locked_o | output | 1 | Frame alignment lock |

## Verification
The final bit pair of a frame is registered on one edge. The frame decision is taken from that registered history, and `valid_o`, `sample_o` and `locked_o` all change on the following edge. When the frame starts on an odd bit, the last bit of the frame arrives one cycle later, inside the next frame's first pair, so every result moves one cycle later as well.

The driver pushes an expected word into a queue only when its own frame-level lock model says the word is due. The monitor pops that word on the negative edge after each strobe, so order and count are checked without tying the check to a fixed cycle. The lock flag and the zeroed sample are checked on the exact cycle they are due: the second cycle of each frame, or the third cycle for an odd start.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
    localparam int LANES   = 3;
    localparam int LANE_HI = 0;
    localparam int LANE_LO = 1;
    localparam int LANE_FR = 2;
endpackage

// File: rtl/lwd_lane_hist.sv
module lwd_lane_hist #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   pair,
    output logic [W-1:0] hist
);
    logic [W-1:0] hist_d, hist_q;

    // newest pair enters at the bottom; the rising-edge bit is the older one
    always_comb hist_d = {hist_q[W-3:0], pair};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;
endmodule

// File: rtl/lwd_frame_lock.sv
module lwd_frame_lock #(
    parameter int BYTE_W      = 8,
    parameter int LOCK_HITS   = 4,
    parameter int DROP_MISSES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BYTE_W:0] fr_hist,
    output logic            emit,
    output logic            drop,
    output logic            locked,
    output logic            off
);
    localparam int CYC    = BYTE_W / 2;
    localparam int CNT_W  = (CYC > 1) ? $clog2(CYC) : 1;
    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(DROP_MISSES + 1);
    localparam logic [BYTE_W-1:0] MARK = {{(BYTE_W/2){1'b1}}, {(BYTE_W/2){1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  phase;
        logic              off;
        logic              cand;
        logic [HIT_W-1:0]  hits;
        logic [MISS_W-1:0] miss;
        logic              lock;
    } st_t;

    st_t st_d, st_q;
    logic m_even, m_odd, hit, slot, search;

    assign m_even = (fr_hist[BYTE_W-1:0] == MARK);
    assign m_odd  = (fr_hist[BYTE_W:1]   == MARK);

    always_comb begin
        st_d   = st_q;
        emit   = 1'b0;
        drop   = 1'b0;
        st_d.cnt = (st_q.cnt == CNT_W'(CYC - 1)) ? '0 : st_q.cnt + 1'b1;
        slot   = st_q.cand && (st_q.cnt == st_q.phase);
        hit    = st_q.off ? m_odd : m_even;
        search = !st_q.cand;

        if (slot) begin
            if (st_q.lock) begin
                if (hit) begin
                    st_d.miss = '0;
                    emit      = 1'b1;
                end else if (st_q.miss == MISS_W'(DROP_MISSES - 1)) begin
                    drop      = 1'b1;
                    st_d.lock = 1'b0;
                    st_d.cand = 1'b0;
                    st_d.hits = '0;
                    st_d.miss = '0;
                    search    = 1'b1;
                end else begin
                    st_d.miss = st_q.miss + 1'b1;
                    emit      = 1'b1;
                end
            end else if (hit) begin
                st_d.hits = st_q.hits + 1'b1;
                if (st_q.hits == HIT_W'(LOCK_HITS - 1)) begin
                    st_d.lock = 1'b1;
                    st_d.miss = '0;
                end
            end else begin
                st_d.cand = 1'b0;
                st_d.hits = '0;
                search    = 1'b1;
            end
        end

        if (search && (m_even || m_odd)) begin
            st_d.cand  = 1'b1;
            st_d.off   = !m_even;
            st_d.phase = st_q.cnt;
            st_d.hits  = HIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;
    assign off    = st_q.off;
endmodule

// File: rtl/lwd_word_pack.sv
module lwd_word_pack #(
    parameter int BYTE_W   = 8,
    parameter int SAMPLE_W = 14,
    parameter int HI_W     = 7
) (
    input  logic [HI_W-1:0]   hi_hist,
    input  logic [BYTE_W:0]   lo_hist,
    input  logic              off,
    input  logic              fmt_offset,
    output logic [2*BYTE_W-1:0] word
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int UP_W   = SAMPLE_W - BYTE_W;

    logic [UP_W-1:0]     up_part;
    logic [BYTE_W-1:0]   lo_part;
    logic [SAMPLE_W-1:0] raw;
    logic                sgn;

    always_comb begin
        // one offset serves both lanes, so both bytes come from one frame
        up_part = hi_hist[off +: UP_W];
        lo_part = lo_hist[off +: BYTE_W];
        raw     = {up_part, lo_part};
        sgn     = raw[SAMPLE_W-1] ^ fmt_offset;
        word    = {{(WORD_W - SAMPLE_W + 1){sgn}}, raw[SAMPLE_W-2:0]};
    end
endmodule

// File: rtl/lvds_word_deser.sv
module lvds_word_deser #(
    parameter int BYTE_W      = 8,
    parameter int SAMPLE_W    = 14,
    parameter int LOCK_HITS   = 4,
    parameter int DROP_MISSES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hi_rise,
    input  logic                  hi_fall,
    input  logic                  lo_rise,
    input  logic                  lo_fall,
    input  logic                  fr_rise,
    input  logic                  fr_fall,
    input  logic                  fmt_offset,
    output logic [2*BYTE_W-1:0]   sample_o,
    output logic                  valid_o,
    output logic                  locked_o
);
    import lwd_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;
    localparam int FULL_W = BYTE_W + 1;
    localparam int HI_W   = SAMPLE_W - BYTE_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] sample;
        logic              valid;
    } out_t;

    logic [1:0]        pair [LANES];
    logic [HI_W-1:0]   hi_hist;
    logic [FULL_W-1:0] lo_hist, fr_hist;
    logic              emit, drop, locked, off;
    logic [WORD_W-1:0] word;
    out_t              out_d, out_q;

    assign pair[LANE_HI] = {hi_rise, hi_fall};
    assign pair[LANE_LO] = {lo_rise, lo_fall};
    assign pair[LANE_FR] = {fr_rise, fr_fall};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == LANE_HI) begin : g_hi
            lwd_lane_hist #(.W(HI_W)) u_hist (
                .clk(clk), .rst_n(rst_n), .pair(pair[g]), .hist(hi_hist));
        end else if (g == LANE_LO) begin : g_lo
            lwd_lane_hist #(.W(FULL_W)) u_hist (
                .clk(clk), .rst_n(rst_n), .pair(pair[g]), .hist(lo_hist));
        end else begin : g_fr
            lwd_lane_hist #(.W(FULL_W)) u_hist (
                .clk(clk), .rst_n(rst_n), .pair(pair[g]), .hist(fr_hist));
        end
    end

    lwd_frame_lock #(
        .BYTE_W(BYTE_W), .LOCK_HITS(LOCK_HITS), .DROP_MISSES(DROP_MISSES)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .fr_hist(fr_hist),
        .emit(emit), .drop(drop), .locked(locked), .off(off));

    lwd_word_pack #(
        .BYTE_W(BYTE_W), .SAMPLE_W(SAMPLE_W), .HI_W(HI_W)
    ) u_pack (
        .hi_hist(hi_hist), .lo_hist(lo_hist), .off(off),
        .fmt_offset(fmt_offset), .word(word));

    always_comb begin
        out_d.valid = emit;
        if (emit)                out_d.sample = word;
        else if (!locked || drop) out_d.sample = '0;
        else                     out_d.sample = out_q.sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sample_o = out_q.sample;
    assign valid_o  = out_q.valid;
    assign locked_o = locked;
endmodule

// File: rtl/lvds_word_deser_chk.sv
module lvds_word_deser_chk #(
    parameter int WORD_W   = 16,
    parameter int SAMPLE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] sample_o,
    input logic              valid_o,
    input logic              locked_o
);
    logic [WORD_W-SAMPLE_W:0] top_bits;
    assign top_bits = sample_o[WORD_W-1:SAMPLE_W-1];

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(locked_o)); // R9
    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_ZERO_WHILE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> (sample_o == '0 && !valid_o)); // R10
    AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((&top_bits) || !(|top_bits))); // R7
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o) && !valid_o) |-> $stable(sample_o)); // R9
endmodule

bind lvds_word_deser lvds_word_deser_chk #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_o(sample_o), .valid_o(valid_o), .locked_o(locked_o));

// File: tb/sim_lvds_word_deser.sv
`timescale 1ns/1ps
module sim_lvds_word_deser;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_rise = 0, hi_fall = 0, lo_rise = 0, lo_fall = 0, fr_rise = 0, fr_fall = 0;
    logic fmt_offset = 1'b0;
    logic [15:0] sample_o;
    logic valid_o, locked_o;

    int checks = 0;
    int failures = 0;

    bit hq[$], lq[$], fq[$];
    logic [15:0] expq[$];
    int  shift = 0;
    bit  m_lock = 0;
    int  m_hits = 0, m_miss = 0;

    always #2.5 clk = ~clk;

    lvds_word_deser u0 (
        .clk(clk), .rst_n(rst_n),
        .hi_rise(hi_rise), .hi_fall(hi_fall),
        .lo_rise(lo_rise), .lo_fall(lo_fall),
        .fr_rise(fr_rise), .fr_fall(fr_fall),
        .fmt_offset(fmt_offset),
        .sample_o(sample_o), .valid_o(valid_o), .locked_o(locked_o));

    function automatic logic [15:0] expv(logic [13:0] v, bit f);
        logic [13:0] t;
        t = v ^ {f, 13'b0};
        return {{2{t[13]}}, t};
    endfunction

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on every strobe (R2 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (expq.size() == 0) chk(0, "R9 unexpected strobe", sample_o, 16'h0);
            else begin
                logic [15:0] e;
                e = expq.pop_front();
                chk(sample_o == e, "R2 R6 R7 R8 word", sample_o, e);
            end
        end
    end

    task automatic do_reset(int sh, bit fmt);
        rst_n = 0;
        hq.delete(); lq.delete(); fq.delete(); expq.delete();
        m_lock = 0; m_hits = 0; m_miss = 0;
        shift = sh; fmt_offset = fmt;
        {hi_rise, hi_fall, lo_rise, lo_fall, fr_rise, fr_fall} = '0;
        repeat (3) @(negedge clk);
        chk(sample_o == 0 && !valid_o && !locked_o, "R1 reset state",
            {valid_o, locked_o, sample_o[13:0]}, 16'h0);
        rst_n = 1;
        for (int i = 0; i < sh; i++) begin hq.push_back(0); lq.push_back(0); fq.push_back(0); end
    endtask

    task automatic send_frame(logic [13:0] v, logic [1:0] pad, bit good);
        logic [15:0] w;
        logic [7:0]  fp;
        bit          prev;
        w    = {pad, v};
        fp   = good ? 8'hF0 : 8'h00;
        prev = m_lock;
        for (int i = 7; i >= 0; i--) begin
            hq.push_back(w[8+i]); lq.push_back(w[i]); fq.push_back(fp[i]);
        end
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            if (p == 1 + shift) begin
                chk(locked_o == prev, "R3 R4 R5 lock flag", {15'b0, locked_o}, {15'b0, prev});
                if (!prev) chk(sample_o == 0, "R10 zero while unlocked", sample_o, 16'h0);
            end
            hi_rise = hq.pop_front(); hi_fall = hq.pop_front();
            lo_rise = lq.pop_front(); lo_fall = lq.pop_front();
            fr_rise = fq.pop_front(); fr_fall = fq.pop_front();
        end
        if (!m_lock) begin
            if (good) begin
                m_hits++;
                if (m_hits == 4) begin m_lock = 1; m_miss = 0; end
            end else m_hits = 0;
        end else if (good) begin
            m_miss = 0;
            expq.push_back(expv(v, fmt_offset));
        end else begin
            m_miss++;
            if (m_miss == 2) begin m_lock = 0; m_hits = 0; m_miss = 0; end
            else expq.push_back(expv(v, fmt_offset));
        end
    endtask

    task automatic finish_run(string tag);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            hi_rise = (hq.size() > 0) ? hq.pop_front() : 0; hi_fall = 0;
            lo_rise = (lq.size() > 0) ? lq.pop_front() : 0; lo_fall = 0;
            fr_rise = (fq.size() > 0) ? fq.pop_front() : 0; fr_fall = 0;
        end
        @(negedge clk);
        chk(expq.size() == 0, tag, 16'(expq.size()), 16'h0);
    endtask

    task automatic run_scenario(int sh, bit fmt);
        logic [13:0] vals [16];
        vals = '{14'h0000, 14'h1FFF, 14'h2000, 14'h3FFF, 14'h00FF, 14'h0100, 14'h01FF, 14'h0200,
                 14'h2AAA, 14'h1555, 14'h3F00, 14'h00FF, 14'h0100, 14'h1234, 14'h2345, 14'h3210};
        do_reset(sh, fmt);
        // R3 R4: lock after four frames; R6: byte wraps; R7: pads vary
        for (int i = 0; i < 16; i++) send_frame(vals[i], 2'(i), 1);
        // R5: single miss keeps lock and word
        send_frame(14'h0ABC, 2'b10, 0);
        for (int i = 0; i < 3; i++) send_frame(vals[i+4], 2'b01, 1);
        // R5: two misses drop lock, then relock after four
        send_frame(14'h1111, 2'b11, 0);
        send_frame(14'h2222, 2'b00, 0);
        for (int i = 0; i < 7; i++) send_frame(vals[i+8], 2'(3 - i % 4), 1);
        finish_run("R9 all expected words delivered");
    endtask

    initial begin
        run_scenario(0, 0);
        run_scenario(1, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule